// File: doc/BRIEF.md
# Multi-Mode Interrupt Vector Generator

This block works out the program address that an 8-bit processor core jumps to when it takes an interrupt. A non-maskable request always goes to a single fixed entry. A maskable request is served in one of three modes that software selects. In restart mode the interrupting device returns an opcode byte during acknowledge, and the block turns that byte into one of eight entries spaced eight bytes apart. In fixed mode every maskable request goes to one address. In table mode the block builds a pointer from a page register and a device byte, then reads a two-byte handler address from memory.

The block also supplies the start address after reset. Requests are accepted only while the controller is idle. A whole sequence runs as a fixed chain of named states. `ST_BOOT` is the reset state and moves to `ST_IDLE`. From `ST_IDLE` the controller goes to `ST_NMI` on a non-maskable request. On an enabled maskable request it goes to `ST_FIXED` (fixed mode) or to `ST_ACK` (restart and table modes). `ST_ACK` moves to `ST_RST_OUT` in restart mode, or to `ST_RD_LO`, then `ST_RD_HI`, then `ST_TBL_OUT` in table mode. Every output state (`ST_NMI`, `ST_FIXED`, `ST_RST_OUT`, `ST_TBL_OUT`) returns to `ST_IDLE`.

Top module: `intvec_gen`

## Requirements
- R1: While reset is asserted the block presents `target_valid`=1 with `target_addr`=0000h. After reset the mode is restart mode (0).
- R2: A non-maskable request seen in idle gives `target_valid` with `target_addr`=0066h in the next cycle, whatever the mode and `int_en`.
- R3: When a non-maskable and an enabled maskable request are both present in idle, only the non-maskable one is served: no acknowledge, address 0066h.
- R4: With `int_en`=0 a maskable request is ignored: no acknowledge, no memory read, no target, no error.
- R5: In restart mode (0) `int_ack` is high in the cycle after the request. `dev_byte` is sampled in that cycle. If bits 7:6 and 2:0 of that byte are all ones, the next cycle gives `target_valid` with `target_addr` = bits 5:3 × 8.
- R6: In restart mode a sampled byte that does not match that pattern gives a one-cycle `illegal_vec` pulse and no target.
- R7: In fixed mode (1) a maskable request gives `target_valid` with `target_addr`=0038h in the next cycle, with no acknowledge.
- R8: In table mode (2) acknowledge takes one cycle. Then two reads follow, at {`page_reg`, `dev_byte`[7:1], 0} and at that address + 1. In the cycle after the second read, `target_addr` = {byte at the second address, byte at the first address}.
- R9: A pulse on `mode_set` loads `mode_sel` values 0, 1 or 2 into the mode. The value 3 leaves the mode unchanged.
- R10: In any cycle at most one of `int_ack`, `mem_rd`, `target_valid` and `illegal_vec` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_set | input | 1 | Load `mode_sel` into the mode register |
| mode_sel | input | 2 | Requested mode: 0 restart, 1 fixed, 2 table |
| int_en | input | 1 | Maskable request enable |
| int_req | input | 1 | Maskable interrupt request |
| nmi_req | input | 1 | Non-maskable interrupt request |
| page_reg | input | 8 | Table page, becomes pointer bits 15:8 |
| dev_byte | input | 8 | Byte driven by the device during acknowledge |
| int_ack | output | 1 | Acknowledge cycle; device drives `dev_byte` |
| mem_rd | output | 1 | Table byte read strobe |
| mem_addr | output | 16 | Table read address |
| mem_data | input | 8 | Read data, valid in the same cycle as `mem_rd` |
| target_valid | output | 1 | `target_addr` holds a jump address |
| target_addr | output | 16 | Computed jump address |
| illegal_vec | output | 1 | Restart-mode byte was not a restart opcode |

## Verification
The hardest case to reach is the table path. The result depends on two memory bytes read in back-to-back cycles, so the bench needs a memory model that answers each address with a different byte. The bench's memory returns a byte computed from the address. It sweeps every device byte against several pages, so a swapped byte order, a wrong pointer bit 0 or a read from the wrong page gives a different target. Restart mode is swept over all 256 device bytes, which splits legal opcodes from illegal ones exactly at the bit pattern.

// File: rtl/intvec_pkg.sv
package intvec_pkg;

    typedef enum logic [3:0] {
        ST_BOOT,
        ST_IDLE,
        ST_ACK,
        ST_FIXED,
        ST_NMI,
        ST_RST_OUT,
        ST_RD_LO,
        ST_RD_HI,
        ST_TBL_OUT
    } vec_state_e;

    typedef enum logic [1:0] {
        MODE_RST = 2'd0,
        MODE_FIX = 2'd1,
        MODE_TBL = 2'd2
    } vec_mode_e;

endpackage

// File: rtl/intvec_mode_reg.sv
module intvec_mode_reg
    import intvec_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_set,
    input  logic [1:0] mode_sel,
    output vec_mode_e  mode_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_RST;
        end else if (mode_set && mode_sel != 2'd3) begin
            mode_q <= vec_mode_e'(mode_sel);
        end
    end

endmodule

// File: rtl/intvec_ctrl.sv
module intvec_ctrl
    import intvec_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       nmi_req,
    input  logic       int_req,
    input  logic       int_en,
    input  vec_mode_e  mode_q,
    input  logic       rst_legal,
    output vec_state_e st,
    output logic       int_ack,
    output logic       mem_rd,
    output logic       target_valid,
    output logic       illegal_vec
);

    vec_state_e st_nx;
    logic       tbl_q;
    logic       tbl_nx;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= ST_BOOT;
            tbl_q <= 1'b0;
        end else begin
            st    <= st_nx;
            tbl_q <= tbl_nx;
        end
    end

    // next state
    always_comb begin
        st_nx  = st;
        tbl_nx = tbl_q;
        unique case (st)
            ST_BOOT: st_nx = ST_IDLE;
            ST_IDLE: begin
                if (nmi_req) begin
                    st_nx = ST_NMI;
                end else if (int_req && int_en) begin
                    case (mode_q)
                        MODE_FIX: st_nx = ST_FIXED;
                        MODE_RST: begin
                            st_nx  = ST_ACK;
                            tbl_nx = 1'b0;
                        end
                        MODE_TBL: begin
                            st_nx  = ST_ACK;
                            tbl_nx = 1'b1;
                        end
                        default: st_nx = ST_IDLE;
                    endcase
                end
            end
            ST_ACK:     st_nx = tbl_q ? ST_RD_LO : ST_RST_OUT;
            ST_RD_LO:   st_nx = ST_RD_HI;
            ST_RD_HI:   st_nx = ST_TBL_OUT;
            ST_FIXED,
            ST_NMI,
            ST_RST_OUT,
            ST_TBL_OUT: st_nx = ST_IDLE;
            default:    st_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        int_ack      = 1'b0;
        mem_rd       = 1'b0;
        target_valid = 1'b0;
        illegal_vec  = 1'b0;
        unique case (st)
            ST_ACK:     int_ack = 1'b1;
            ST_RD_LO,
            ST_RD_HI:   mem_rd = 1'b1;
            ST_BOOT,
            ST_FIXED,
            ST_NMI,
            ST_TBL_OUT: target_valid = 1'b1;
            ST_RST_OUT: begin
                target_valid = rst_legal;
                illegal_vec  = !rst_legal;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/intvec_datapath.sv
module intvec_datapath
    import intvec_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 2 * DATA_W,
    parameter logic [ADDR_W-1:0] RESET_VEC = 16'h0000,
    parameter logic [ADDR_W-1:0] NMI_VEC   = 16'h0066,
    parameter logic [ADDR_W-1:0] FIXED_VEC = 16'h0038
) (
    input  logic              clk,
    input  logic              rst_n,
    input  vec_state_e        st,
    input  logic [DATA_W-1:0] page_reg,
    input  logic [DATA_W-1:0] dev_byte,
    input  logic [DATA_W-1:0] mem_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [ADDR_W-1:0] target_addr,
    output logic              rst_legal
);

    localparam int SLOT_LSB = 3;
    localparam int SLOT_W   = 3;
    localparam int PAD_W    = ADDR_W - SLOT_W - SLOT_LSB;

    logic [DATA_W-1:0] dev_q;
    logic [DATA_W-1:0] lo_q;
    logic [DATA_W-1:0] hi_q;
    logic [ADDR_W-1:0] rst_target;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dev_q <= '0;
            lo_q  <= '0;
            hi_q  <= '0;
        end else begin
            if (st == ST_ACK)   dev_q <= dev_byte;
            if (st == ST_RD_LO) lo_q  <= mem_data;
            if (st == ST_RD_HI) hi_q  <= mem_data;
        end
    end

    assign rst_legal  = (dev_q[DATA_W-1:DATA_W-2] == 2'b11) && (dev_q[2:0] == 3'b111);
    assign rst_target = {{PAD_W{1'b0}}, dev_q[SLOT_LSB +: SLOT_W], {SLOT_LSB{1'b0}}};
    assign mem_addr   = {page_reg, dev_q[DATA_W-1:1], (st == ST_RD_HI)};

    always_comb begin
        target_addr = '0;
        unique case (st)
            ST_BOOT:    target_addr = RESET_VEC;
            ST_NMI:     target_addr = NMI_VEC;
            ST_FIXED:   target_addr = FIXED_VEC;
            ST_RST_OUT: target_addr = rst_legal ? rst_target : '0;
            ST_TBL_OUT: target_addr = {hi_q, lo_q};
            default:    target_addr = '0;
        endcase
    end

endmodule

// File: rtl/intvec_gen.sv
module intvec_gen
    import intvec_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 2 * DATA_W,
    parameter logic [ADDR_W-1:0] RESET_VEC = 16'h0000,
    parameter logic [ADDR_W-1:0] NMI_VEC   = 16'h0066,
    parameter logic [ADDR_W-1:0] FIXED_VEC = 16'h0038
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_set,
    input  logic [1:0]        mode_sel,
    input  logic              int_en,
    input  logic              int_req,
    input  logic              nmi_req,
    input  logic [DATA_W-1:0] page_reg,
    input  logic [DATA_W-1:0] dev_byte,
    output logic              int_ack,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_data,
    output logic              target_valid,
    output logic [ADDR_W-1:0] target_addr,
    output logic              illegal_vec
);

    vec_mode_e  mode_q;
    vec_state_e st;
    logic       rst_legal;

    intvec_mode_reg u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_set (mode_set),
        .mode_sel (mode_sel),
        .mode_q   (mode_q)
    );

    intvec_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .nmi_req      (nmi_req),
        .int_req      (int_req),
        .int_en       (int_en),
        .mode_q       (mode_q),
        .rst_legal    (rst_legal),
        .st           (st),
        .int_ack      (int_ack),
        .mem_rd       (mem_rd),
        .target_valid (target_valid),
        .illegal_vec  (illegal_vec)
    );

    intvec_datapath #(
        .DATA_W    (DATA_W),
        .ADDR_W    (ADDR_W),
        .RESET_VEC (RESET_VEC),
        .NMI_VEC   (NMI_VEC),
        .FIXED_VEC (FIXED_VEC)
    ) u_dp (
        .clk         (clk),
        .rst_n       (rst_n),
        .st          (st),
        .page_reg    (page_reg),
        .dev_byte    (dev_byte),
        .mem_data    (mem_data),
        .mem_addr    (mem_addr),
        .target_addr (target_addr),
        .rst_legal   (rst_legal)
    );

endmodule

// File: rtl/intvec_gen_chk.sv
module intvec_gen_chk
    import intvec_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] RESET_VEC = 16'h0000,
    parameter logic [ADDR_W-1:0] NMI_VEC   = 16'h0066,
    parameter logic [ADDR_W-1:0] FIXED_VEC = 16'h0038
) (
    input logic              clk,
    input logic              rst_n,
    input vec_state_e        st,
    input vec_mode_e         mode_q,
    input logic              nmi_req,
    input logic              int_req,
    input logic              int_en,
    input logic              int_ack,
    input logic              mem_rd,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              target_valid,
    input logic [ADDR_W-1:0] target_addr,
    input logic              illegal_vec
);

    logic booted;

    always_ff @(posedge clk) begin
        if (!rst_n) booted <= 1'b0;
        else        booted <= 1'b1;
    end

    // R1
    boot_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !booted |-> (target_valid && target_addr == RESET_VEC && mode_q == MODE_RST));

    // R2
    nmi_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && nmi_req) |=> (target_valid && target_addr == NMI_VEC && !int_ack));

    // R4
    masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && !nmi_req && !(int_req && int_en))
        |=> (!target_valid && !int_ack && !mem_rd && !illegal_vec));

    // R7
    fixed_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && !nmi_req && int_req && int_en && mode_q == MODE_FIX)
        |=> (target_valid && target_addr == FIXED_VEC));

    // R8
    table_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && !mem_addr[0]) |=> (mem_rd && mem_addr == $past(mem_addr) + ADDR_W'(1)));

    // R10
    one_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({int_ack, mem_rd, target_valid, illegal_vec}));

endmodule

bind intvec_gen intvec_gen_chk #(
    .ADDR_W    (ADDR_W),
    .RESET_VEC (RESET_VEC),
    .NMI_VEC   (NMI_VEC),
    .FIXED_VEC (FIXED_VEC)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .st           (st),
    .mode_q       (mode_q),
    .nmi_req      (nmi_req),
    .int_req      (int_req),
    .int_en       (int_en),
    .int_ack      (int_ack),
    .mem_rd       (mem_rd),
    .mem_addr     (mem_addr),
    .target_valid (target_valid),
    .target_addr  (target_addr),
    .illegal_vec  (illegal_vec)
);

// File: tb/intvec_gen_test.sv
module intvec_gen_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_set = 1'b0;
    logic [1:0]  mode_sel = 2'd0;
    logic        int_en = 1'b1;
    logic        int_req = 1'b0;
    logic        nmi_req = 1'b0;
    logic [7:0]  page_reg = 8'h00;
    logic [7:0]  dev_byte = 8'h00;
    logic        int_ack;
    logic        mem_rd;
    logic [15:0] mem_addr;
    logic [7:0]  mem_data;
    logic        target_valid;
    logic [15:0] target_addr;
    logic        illegal_vec;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    function automatic logic [7:0] mem_fn(input logic [15:0] a);
        return a[15:8] ^ {a[6:0], a[7]} ^ 8'hA5;
    endfunction

    assign mem_data = mem_fn(mem_addr);

    intvec_gen uut (
        .clk(clk), .rst_n(rst_n), .mode_set(mode_set), .mode_sel(mode_sel),
        .int_en(int_en), .int_req(int_req), .nmi_req(nmi_req),
        .page_reg(page_reg), .dev_byte(dev_byte), .int_ack(int_ack),
        .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_data(mem_data),
        .target_valid(target_valid), .target_addr(target_addr),
        .illegal_vec(illegal_vec)
    );

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_chk  = n_chk + 1;
            n_fail = n_fail + 1;
            $display("FAIL watchdog: act=%0d cycles exp<=150000", cyc);
            summary();
        end
    end

    task automatic check(input string tag, input logic ok, input logic [31:0] act, input logic [31:0] exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic set_mode(input logic [1:0] m);
        @(negedge clk);
        mode_sel = m;
        mode_set = 1'b1;
        @(negedge clk);
        mode_set = 1'b0;
    endtask

    // Raise requests for one edge, then watch 6 cycles. Result: cycle of
    // first target/illegal, its kind and address, cycle of ack, read count.
    task automatic run(input logic use_nmi, input logic use_int, input string tag,
                       input int exp_cyc, input logic exp_ill, input logic [15:0] exp_addr,
                       input int exp_ack, input int exp_rd);
        int hit = 0;
        int ackc = 0;
        int rds = 0;
        logic ill = 1'b0;
        logic [15:0] addr = '0;
        @(negedge clk);
        nmi_req = use_nmi;
        int_req = use_int;
        for (int i = 1; i <= 6; i++) begin
            @(negedge clk);
            if (i == 1) begin
                nmi_req = 1'b0;
                int_req = 1'b0;
            end
            if (int_ack && ackc == 0) ackc = i;
            if (mem_rd) rds = rds + 1;
            if ((target_valid || illegal_vec) && hit == 0) begin
                hit  = i;
                ill  = illegal_vec;
                addr = target_addr;
            end
        end
        check({tag, " cycle"}, hit == exp_cyc, 32'(hit), 32'(exp_cyc));
        if (exp_cyc != 0) begin
            check({tag, " kind"}, ill == exp_ill, 32'(ill), 32'(exp_ill));
            if (!exp_ill) check({tag, " addr"}, addr == exp_addr, 32'(addr), 32'(exp_addr));
        end
        check({tag, " ack"}, ackc == exp_ack, 32'(ackc), 32'(exp_ack));
        check({tag, " reads"}, rds == exp_rd, 32'(rds), 32'(exp_rd));
    endtask

    initial begin
        // R1: reset state
        #1;
        @(negedge clk);
        check("R1 reset target", target_valid && target_addr == 16'h0000, 32'(target_addr), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after boot", !target_valid, 32'(target_valid), 32'h0);

        // R1 + R5: default mode is restart, full sweep of device byte
        for (int b = 0; b < 256; b++) begin
            logic legal;
            dev_byte = 8'(b);
            legal = (b[7:6] == 2'b11) && (b[2:0] == 3'b111);
            run(1'b0, 1'b1, legal ? "R5 restart" : "R6 illegal", 2, !legal,
                16'(((b >> 3) & 7) * 8), 1, 0);
        end

        // R7: fixed mode
        set_mode(2'd1);
        dev_byte = 8'hFF;
        run(1'b0, 1'b1, "R7 fixed", 1, 1'b0, 16'h0038, 0, 0);
        // R9: value 3 leaves mode at fixed
        set_mode(2'd3);
        run(1'b0, 1'b1, "R9 mode3 ignored", 1, 1'b0, 16'h0038, 0, 0);

        // R4: masked request in every mode
        int_en = 1'b0;
        run(1'b0, 1'b1, "R4 masked fixed", 0, 1'b0, 16'h0, 0, 0);
        set_mode(2'd0);
        run(1'b0, 1'b1, "R4 masked restart", 0, 1'b0, 16'h0, 0, 0);
        // R2: NMI ignores mask
        run(1'b1, 1'b0, "R2 nmi masked", 1, 1'b0, 16'h0066, 0, 0);
        int_en = 1'b1;

        // R8: table mode sweep
        set_mode(2'd2);
        for (int p = 0; p < 4; p++) begin
            page_reg = (p == 0) ? 8'h00 : (p == 1) ? 8'h12 : (p == 2) ? 8'h7F : 8'hFF;
            for (int b = 0; b < 256; b++) begin
                logic [15:0] ptr;
                dev_byte = 8'(b);
                ptr = {page_reg, dev_byte[7:1], 1'b0};
                run(1'b0, 1'b1, "R8 table", 4, 1'b0,
                    {mem_fn(ptr + 16'd1), mem_fn(ptr)}, 1, 2);
            end
        end
        int_en = 1'b0;
        run(1'b0, 1'b1, "R4 masked table", 0, 1'b0, 16'h0, 0, 0);
        int_en = 1'b1;

        // R3: NMI beats maskable in each mode; R2 in each mode
        run(1'b1, 1'b1, "R3 nmi wins table", 1, 1'b0, 16'h0066, 0, 0);
        set_mode(2'd1);
        run(1'b1, 1'b1, "R3 nmi wins fixed", 1, 1'b0, 16'h0066, 0, 0);
        set_mode(2'd0);
        run(1'b1, 1'b1, "R3 nmi wins restart", 1, 1'b0, 16'h0066, 0, 0);

        // R9: explicit return to table then reset back to restart (R1)
        set_mode(2'd2);
        page_reg = 8'h40;
        dev_byte = 8'h21;
        run(1'b0, 1'b1, "R9 table selected", 4, 1'b0,
            {mem_fn(16'h4021), mem_fn(16'h4020)}, 1, 2);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset again", target_valid && target_addr == 16'h0000, 32'(target_addr), 32'h0);
        rst_n = 1'b1;
        dev_byte = 8'hEF;
        run(1'b0, 1'b1, "R1 mode0 after reset", 2, 1'b0, 16'h0028, 1, 0);

        summary();
    end

endmodule